// File: doc/BRIEF.md
# GPIO Port with Per-Pin Peripheral Takeover

This block is one general-purpose I/O port of up to 32 pins, programmed through a simple word-addressed write/read register bus. Software owns an output-value register, a direction register, a configuration word per pin and four alias registers. The aliases set or clear bits of the output-value and direction registers without a read-modify-write. The direction bit exists once per pin. It can be reached both through the direction register and through bit 0 of that pin's configuration word, so a write to either is visible through the other.

Any pin can be handed to another on-chip peripheral. There are three takeover controls per pin, and each works independently of the others. The first replaces the output value. The second replaces the direction. The third replaces the input-buffer connect decision. The block combines software state and takeover state into a pad output enable and a pad output value. It samples the resulting pin level through the input buffers into a registered input vector. A one-cycle strobe marks every input bit that has just changed, so that an owning peripheral can react.

Top module: `gpio_port_mux`

## Requirements
- R1: Out of reset the output-value, direction and input vectors are all zero, no pad is driven, no change strobe is raised, and every configuration word reads 0x2 (input direction, buffer disconnected).
- R2: A bus write takes effect on the next clock. Word offset 0 loads the output-value register. Offset 1 ORs the written mask into it. Offset 2 clears the bits set in the written mask.
- R3: Reading offset 1 returns the output-value register and reading offset 5 returns the direction register. Offsets 2 and 6 always read zero.
- R4: Offset 4 loads the direction register. Offset 5 ORs the written mask into it and offset 6 clears the masked bits.
- R5: A write to offset 4, 5 or 6 changes bit 0 of each affected pin's configuration word (offset 8 + pin). A configuration write changes that pin's direction bit, and the new value reads back at offset 4.
- R6: In a configuration word, bit 1 is input disconnect (1 = disconnected), bit 5 is sense enable and bit 4 is sense polarity invert. These three bits are stored and read back. Every other bit of the word reads zero.
- R7: The effective output value of a pin is the peripheral value where that pin's output takeover is set, and the output-value register bit elsewhere.
- R8: The effective direction of a pin is the peripheral direction where its direction takeover is set, and the direction register bit elsewhere. The pad output enable equals the effective direction. The pad output value is the effective output value gated by the effective direction, so a pin that stops driving while high goes low.
- R9: The input enable of a pin is the peripheral connect bit where its input takeover is set, and the inverse of the configuration disconnect bit elsewhere. The input vector (offset 3 and the pin_in output) becomes pin level AND input enable one clock later.
- R10: When a pin's effective direction is output, its level is its own driven value, and the external pad input has no effect on the input vector.
- R11: A pin's change strobe is high for exactly the cycle in which its input-vector bit differs from the previous cycle's value.
- R12: Writes to offset 3, to offset 7 and to offsets beyond the last configuration word change no state. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Word offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register, combinational |
| per_out_ovr | input | NUM_PINS | Per-pin output value takeover |
| per_out_val | input | NUM_PINS | Output value supplied by the owning peripheral |
| per_dir_ovr | input | NUM_PINS | Per-pin direction takeover |
| per_dir_val | input | NUM_PINS | Direction supplied by the owning peripheral (1 = output) |
| per_in_ovr | input | NUM_PINS | Per-pin input-buffer takeover |
| per_in_conn | input | NUM_PINS | Input-buffer connect supplied by the owning peripheral |
| pad_in | input | NUM_PINS | Level driven onto the pads from outside |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_out | output | NUM_PINS | Pad output value |
| pin_in | output | NUM_PINS | Registered input vector |
| pin_in_chg | output | NUM_PINS | One-cycle strobe per changed input bit |

## Verification
The bench builds the block with its defaults: 32 pins, a 6-bit word offset and 32-bit data. With these values a full-width mask exercises every pin, and the last configuration word sits at offset 39, the top of the mapped range. Offsets 40 to 63 are then in reach to show that unmapped writes change nothing. A behavioural model mirrors the register state and the takeover resolution. Every clock it is compared against the pad outputs, the input vector, the change strobes and the read data of the current offset. This covers mixed takeover patterns and the case of external drive against an output pin.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    // word offsets of the software-visible registers
    localparam int OFS_OUT    = 0;
    localparam int OFS_OUTSET = 1;
    localparam int OFS_OUTCLR = 2;
    localparam int OFS_IN     = 3;
    localparam int OFS_DIR    = 4;
    localparam int OFS_DIRSET = 5;
    localparam int OFS_DIRCLR = 6;
    localparam int OFS_CFG    = 8;

    // bit positions inside a per-pin configuration word
    localparam int CFG_DIR_BIT  = 0;
    localparam int CFG_DISC_BIT = 1;
    localparam int CFG_INV_BIT  = 4;
    localparam int CFG_SEN_BIT  = 5;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [NUM_PINS-1:0] in_q,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] out_q,
    output logic [NUM_PINS-1:0] dir_q,
    output logic [NUM_PINS-1:0] disc_q
);
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [ADDR_W-1:0] A_OUT    = ADDR_W'(OFS_OUT);
    localparam logic [ADDR_W-1:0] A_OUTSET = ADDR_W'(OFS_OUTSET);
    localparam logic [ADDR_W-1:0] A_OUTCLR = ADDR_W'(OFS_OUTCLR);
    localparam logic [ADDR_W-1:0] A_IN     = ADDR_W'(OFS_IN);
    localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_DIRSET = ADDR_W'(OFS_DIRSET);
    localparam logic [ADDR_W-1:0] A_DIRCLR = ADDR_W'(OFS_DIRCLR);
    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_NPIN   = ADDR_W'(NUM_PINS);

    typedef struct packed {
        logic [NUM_PINS-1:0] out;
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] disc;
        logic [NUM_PINS-1:0] sns_en;
        logic [NUM_PINS-1:0] sns_inv;
    } regs_t;

    regs_t             st_d, st_q;
    logic [ADDR_W-1:0] cfg_off;
    logic              cfg_hit;
    logic [IDX_W-1:0]  cfg_idx;
    logic [NUM_PINS-1:0] wmask;

    assign cfg_off = bus_addr - A_CFG;
    assign cfg_hit = (bus_addr >= A_CFG) && (cfg_off < A_NPIN);
    assign cfg_idx = cfg_off[IDX_W-1:0];
    assign wmask   = bus_wdata[NUM_PINS-1:0];

    // next-state computation
    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            if (cfg_hit) begin
                st_d.dir[cfg_idx]     = bus_wdata[CFG_DIR_BIT];
                st_d.disc[cfg_idx]    = bus_wdata[CFG_DISC_BIT];
                st_d.sns_inv[cfg_idx] = bus_wdata[CFG_INV_BIT];
                st_d.sns_en[cfg_idx]  = bus_wdata[CFG_SEN_BIT];
            end else begin
                case (bus_addr)
                    A_OUT:    st_d.out = wmask;
                    A_OUTSET: st_d.out = st_q.out | wmask;
                    A_OUTCLR: st_d.out = st_q.out & ~wmask;
                    A_DIR:    st_d.dir = wmask;
                    A_DIRSET: st_d.dir = st_q.dir | wmask;
                    A_DIRCLR: st_d.dir = st_q.dir & ~wmask;
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.out     <= '0;
            st_q.dir     <= '0;
            st_q.disc    <= '1;
            st_q.sns_en  <= '0;
            st_q.sns_inv <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux: clear aliases read zero, set aliases read the target
    always_comb begin
        bus_rdata = '0;
        if (cfg_hit) begin
            bus_rdata[CFG_DIR_BIT]  = st_q.dir[cfg_idx];
            bus_rdata[CFG_DISC_BIT] = st_q.disc[cfg_idx];
            bus_rdata[CFG_INV_BIT]  = st_q.sns_inv[cfg_idx];
            bus_rdata[CFG_SEN_BIT]  = st_q.sns_en[cfg_idx];
        end else begin
            case (bus_addr)
                A_OUT, A_OUTSET: bus_rdata[NUM_PINS-1:0] = st_q.out;
                A_DIR, A_DIRSET: bus_rdata[NUM_PINS-1:0] = st_q.dir;
                A_IN:            bus_rdata[NUM_PINS-1:0] = in_q;
                default:         bus_rdata = '0;
            endcase
        end
    end

    assign out_q  = st_q.out;
    assign dir_q  = st_q.dir;
    assign disc_q = st_q.disc;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0] out_q,
    input  logic [NUM_PINS-1:0] dir_q,
    input  logic [NUM_PINS-1:0] disc_q,
    input  logic [NUM_PINS-1:0] per_out_ovr,
    input  logic [NUM_PINS-1:0] per_out_val,
    input  logic [NUM_PINS-1:0] per_dir_ovr,
    input  logic [NUM_PINS-1:0] per_dir_val,
    input  logic [NUM_PINS-1:0] per_in_ovr,
    input  logic [NUM_PINS-1:0] per_in_conn,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] in_en,
    output logic [NUM_PINS-1:0] pin_level
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic eff_dir, eff_val, drive;
        assign eff_dir      = per_dir_ovr[i] ? per_dir_val[i] : dir_q[i];
        assign eff_val      = per_out_ovr[i] ? per_out_val[i] : out_q[i];
        assign drive        = eff_dir & eff_val;
        assign pad_oe[i]    = eff_dir;
        assign pad_out[i]   = drive;
        assign in_en[i]     = per_in_ovr[i] ? per_in_conn[i] : ~disc_q[i];
        // an output pin sees its own drive; the outside level is ignored
        assign pin_level[i] = eff_dir ? drive : pad_in[i];
    end
endmodule

// File: rtl/gpio_in_sample.sv
module gpio_in_sample #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] in_en,
    output logic [NUM_PINS-1:0] in_q,
    output logic [NUM_PINS-1:0] chg_q
);
    typedef struct packed {
        logic [NUM_PINS-1:0] in;
        logic [NUM_PINS-1:0] chg;
    } samp_t;

    samp_t s_d, s_q;

    always_comb begin
        s_d.in  = pin_level & in_en;
        s_d.chg = s_d.in ^ s_q.in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_q  = s_q.in;
    assign chg_q = s_q.chg;
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux #(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] per_out_ovr,
    input  logic [NUM_PINS-1:0] per_out_val,
    input  logic [NUM_PINS-1:0] per_dir_ovr,
    input  logic [NUM_PINS-1:0] per_dir_val,
    input  logic [NUM_PINS-1:0] per_in_ovr,
    input  logic [NUM_PINS-1:0] per_in_conn,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_in_chg
);
    logic [NUM_PINS-1:0] out_q, dir_q, disc_q, in_en, pin_level;

    gpio_port_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .in_q      (pin_in),
        .bus_rdata (bus_rdata),
        .out_q     (out_q),
        .dir_q     (dir_q),
        .disc_q    (disc_q)
    );

    gpio_pin_mux #(.NUM_PINS(NUM_PINS)) u_mux (
        .out_q       (out_q),
        .dir_q       (dir_q),
        .disc_q      (disc_q),
        .per_out_ovr (per_out_ovr),
        .per_out_val (per_out_val),
        .per_dir_ovr (per_dir_ovr),
        .per_dir_val (per_dir_val),
        .per_in_ovr  (per_in_ovr),
        .per_in_conn (per_in_conn),
        .pad_in      (pad_in),
        .pad_oe      (pad_oe),
        .pad_out     (pad_out),
        .in_en       (in_en),
        .pin_level   (pin_level)
    );

    gpio_in_sample #(.NUM_PINS(NUM_PINS)) u_samp (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_level (pin_level),
        .in_en     (in_en),
        .in_q      (pin_in),
        .chg_q     (pin_in_chg)
    );
endmodule

// File: rtl/gpio_port_mux_chk.sv
module gpio_port_mux_chk
    import gpio_port_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] out_q,
    input logic [NUM_PINS-1:0] dir_q,
    input logic [NUM_PINS-1:0] in_en,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] pin_in_chg
);
    localparam logic [ADDR_W-1:0] A_OUTSET = ADDR_W'(OFS_OUTSET);
    localparam logic [ADDR_W-1:0] A_OUTCLR = ADDR_W'(OFS_OUTCLR);
    localparam logic [ADDR_W-1:0] A_DIRCLR = ADDR_W'(OFS_DIRCLR);

    a_r2_outset_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_OUTSET) |=>
        ((out_q & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

    a_r4_dirclr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DIRCLR) |=>
        ((dir_q & $past(bus_wdata[NUM_PINS-1:0])) == '0));

    a_r3_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_OUTCLR || bus_addr == A_DIRCLR) |-> (bus_rdata == '0));

    a_r8_idle_pad_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));

    a_r9_disabled_reads_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_in & ~$past(in_en)) == '0));

    a_r10_output_sees_own_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_in & $past(pad_oe & in_en)) == $past(pad_out & pad_oe & in_en)));

    a_r11_strobe_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_in_chg == (pin_in ^ $past(pin_in))));
endmodule

bind gpio_port_mux gpio_port_mux_chk #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .out_q      (out_q),
    .dir_q      (dir_q),
    .in_en      (in_en),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .pin_in     (pin_in),
    .pin_in_chg (pin_in_chg)
);

// File: tb/gpio_port_mux_bench.sv
module gpio_port_mux_bench;
    localparam int N  = 32;
    localparam int AW = 6;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  per_out_ovr = '0, per_out_val = '0;
    logic [N-1:0]  per_dir_ovr = '0, per_dir_val = '0;
    logic [N-1:0]  per_in_ovr = '0, per_in_conn = '0;
    logic [N-1:0]  pad_in = '0;
    logic [N-1:0]  pad_oe, pad_out, pin_in, pin_in_chg;

    always #5 clk = ~clk;

    gpio_port_mux u_gpio_port_mux (
        .clk (clk), .rst_n (rst_n),
        .bus_we (bus_we), .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .per_out_ovr (per_out_ovr), .per_out_val (per_out_val),
        .per_dir_ovr (per_dir_ovr), .per_dir_val (per_dir_val),
        .per_in_ovr (per_in_ovr), .per_in_conn (per_in_conn),
        .pad_in (pad_in), .pad_oe (pad_oe), .pad_out (pad_out),
        .pin_in (pin_in), .pin_in_chg (pin_in_chg)
    );

    // behavioural model state
    logic [N-1:0] m_out = '0, m_dir = '0, m_disc = '1, m_en = '0, m_inv = '0;
    logic [N-1:0] m_in = '0, m_chg = '0;
    int    checks = 0, failures = 0;
    string cur_tag = "R1";
    bit    done = 0;

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    function automatic logic [N-1:0] m_eff_dir();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = per_dir_ovr[i] ? per_dir_val[i] : m_dir[i];
        return r;
    endfunction

    function automatic logic [N-1:0] m_eff_val();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = per_out_ovr[i] ? per_out_val[i] : m_out[i];
        return r;
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [31:0] r = '0;
        if (a >= 8 && a < 8 + N) begin
            r[0] = m_dir[a-8]; r[1] = m_disc[a-8]; r[4] = m_inv[a-8]; r[5] = m_en[a-8];
        end else if (a == 0 || a == 1) r = m_out;
        else if (a == 4 || a == 5) r = m_dir;
        else if (a == 3) r = m_in;
        return r;
    endfunction

    task automatic model_edge();
        logic [N-1:0] d, v, lvl, ie, nin;
        int a;
        d = m_eff_dir();
        v = m_eff_val();
        for (int i = 0; i < N; i++) begin
            lvl[i] = d[i] ? (d[i] & v[i]) : pad_in[i];
            ie[i]  = per_in_ovr[i] ? per_in_conn[i] : !m_disc[i];
        end
        nin = lvl & ie;
        if (bus_we) begin
            a = int'(bus_addr);
            if (a >= 8 && a < 8 + N) begin
                m_dir[a-8] = bus_wdata[0]; m_disc[a-8] = bus_wdata[1];
                m_inv[a-8] = bus_wdata[4]; m_en[a-8]   = bus_wdata[5];
            end else if (a == 0) m_out = bus_wdata;
            else if (a == 1) m_out = m_out | bus_wdata;
            else if (a == 2) m_out = m_out & ~bus_wdata;
            else if (a == 4) m_dir = bus_wdata;
            else if (a == 5) m_dir = m_dir | bus_wdata;
            else if (a == 6) m_dir = m_dir & ~bus_wdata;
        end
        m_chg = nin ^ m_in;
        m_in  = nin;
    endtask

    task automatic compare();
        logic [N-1:0] d;
        d = m_eff_dir();
        chk("pad_oe", pad_oe, d);
        chk("pad_out", pad_out, d & m_eff_val());
        chk("pin_in", pin_in, m_in);
        chk("pin_in_chg", pin_in_chg, m_chg);
        chk($sformatf("rdata@%0d", bus_addr), bus_rdata, m_read(int'(bus_addr)));
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(int a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        cycle();
        bus_we = 1'b0;
    endtask

    task automatic rd(int a);
        bus_addr = AW'(a);
        cycle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        cur_tag = "R1";
        compare();
        rd(8); rd(39); rd(3); rd(4); rd(0);

        cur_tag = "R2";
        wr(0, 32'hA5A5_0F0F); rd(0);
        wr(1, 32'h0000_F000); rd(0);
        wr(2, 32'h0000_000F); rd(0);

        cur_tag = "R3";
        rd(1); rd(2); rd(5); rd(6);

        cur_tag = "R4";
        wr(5, 32'hFF00_FF00); rd(4);
        wr(6, 32'h0F00_0F00); rd(5); rd(6);
        wr(4, 32'h1234_5678); rd(4);

        cur_tag = "R5";
        wr(4, 32'h0000_0001); rd(8); rd(9);
        wr(39, 32'h0000_0001); rd(4); rd(39);
        wr(8, 32'h0000_0002); rd(4);

        cur_tag = "R6";
        wr(10, 32'hFFFF_FFFC); rd(10);
        wr(11, 32'h0000_0012); rd(11);
        wr(12, 32'h0000_0023); rd(12); rd(4);

        cur_tag = "R7";
        wr(4, 32'hFFFF_FFFF);
        wr(0, 32'h0000_0000);
        per_out_ovr = 32'h0000_FFFF; per_out_val = 32'h00FF_00FF; rd(0);
        wr(0, 32'hF0F0_F0F0); rd(0);
        per_out_ovr = '0; rd(0);

        cur_tag = "R8";
        per_dir_ovr = 32'hF0F0_F0F0; per_dir_val = 32'h3030_3030; rd(4);
        wr(6, 32'h0000_00F0); rd(0);
        per_dir_ovr = '0; rd(4);

        cur_tag = "R9";
        wr(4, 32'h0000_0000);
        for (int i = 0; i < N; i++) wr(8 + i, 32'h0000_0000);
        pad_in = 32'hDEAD_BEEF; rd(3); rd(3);
        wr(9, 32'h0000_0002); rd(3);
        per_in_ovr = 32'h0000_00FF; per_in_conn = 32'h0000_000F; rd(3); rd(3);
        per_in_ovr = '0; rd(3);

        cur_tag = "R10";
        wr(0, 32'h0000_FF00);
        wr(4, 32'h00FF_FF00);
        pad_in = 32'hFFFF_FFFF; rd(3); rd(3);
        pad_in = 32'h0000_0000; rd(3); rd(3);
        per_dir_ovr = 32'h0000_0F00; per_dir_val = 32'h0; rd(3); rd(3);
        per_dir_ovr = '0;

        cur_tag = "R11";
        wr(4, 32'h0);
        for (int k = 0; k < 6; k++) begin
            pad_in = (k % 2 == 0) ? 32'h8000_0001 : 32'h0000_0000;
            rd(3);
        end
        rd(3);

        cur_tag = "R12";
        wr(0, 32'h1357_9BDF);
        wr(3, 32'hFFFF_FFFF); rd(3); rd(0);
        wr(7, 32'hFFFF_FFFF); rd(7); rd(0); rd(4);
        wr(40, 32'hFFFF_FFFF); rd(40); rd(8); rd(39);
        wr(63, 32'hFFFF_FFFF); rd(63); rd(0); rd(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_tag);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule